// File: doc/BRIEF.md
# Raster Mix Pixel Read-Modify-Write Engine

The block performs one pixel update in a byte-per-pixel frame buffer. A request names a destination pixel and chooses one of two mix settings, foreground or background. The engine reads the destination byte, picks a source byte, and merges the two with one of sixteen Boolean raster operations. It then writes the result back to the same address. Five 16-bit configuration registers are written and read through a small select/data port: a foreground mix, a background mix, a foreground colour, a background colour and a pixel-transfer word.

Each mix register carries a 4-bit operation code in bits 3:0 and a 2-bit source selector in bits 6:5. The source is the low byte of the background colour (0), the foreground colour (1) or the transfer word (2). Selector 3 takes a byte from a second read port addressed by the request's source address, but only while the bitmap enable input is high; while it is low, selector 3 falls back to the background colour.

The controller is a four-state machine:
- `ST_IDLE` accepts a request and moves to `ST_READ`.
- `ST_READ` issues the memory read and moves to `ST_MIX`.
- `ST_MIX` captures the read data and registers the result, then moves to `ST_WRITE`.
- `ST_WRITE` issues the write and returns to `ST_IDLE`.

The memory port is synchronous, with read data valid one cycle after the read strobe.

Top module: `rop_pixel_rmw`

## Requirements
- R1: While reset (active-low, synchronous) is applied, and on the cycle after it, `req_ready` is 1, `done`, `mem_rd_en` and `mem_wr_en` are 0, and all five configuration registers read 0.
- R2: A config write with `cfg_sel` 0 (foreground mix), 1 (background mix), 2 (foreground colour), 3 (background colour) or 4 (transfer word) stores all 16 bits. `cfg_rdata` returns the selected register combinationally. Selects 5 to 7 read 0.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the next three cycles. `mem_rd_en` is high in the first of them, any write happens in the third, and `done` pulses for one cycle in the fourth, which is idle again.
- R4: A request presented while `req_ready` is 0 is ignored: it causes no memory access and no later write.
- R5: Operation codes 0 to 7 give, bitwise over 8 bits: 0 ~D, 1 all zeros, 2 all ones, 3 D, 4 ~S, 5 S^D, 6 ~(S^D), 7 S.
- R6: Operation codes 8 to 15 give: 8 ~(S&D), 9 ~S|D, 10 S|~D, 11 S|D, 12 S&D, 13 S&~D, 14 ~S&D, 15 ~(S|D).
- R7: With operation code 3, no write strobe is issued, the pixel stays as it was, and `done` still pulses.
- R8: Source selector (mix bits 6:5) 0, 1 and 2 take the low byte of the background colour, foreground colour and transfer word respectively.
- R9: Selector 3 takes the byte read from `bmp_addr` while `bitmap_en` is 1, and the background colour low byte while it is 0.
- R10: Destination and source addresses are reduced modulo `MEM_DEPTH` before they reach `mem_addr` and `bmp_addr`.
- R11: `req_fg` = 1 applies the foreground mix register and `req_fg` = 0 applies the background mix register. The mix is captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected configuration register |
| bitmap_en | input | 1 | Allows source selector 3 to use the second read port |
| req_valid | input | 1 | Pixel request |
| req_fg | input | 1 | 1 = foreground mix, 0 = background mix |
| req_addr | input | REQ_AW | Destination pixel address (wrapped) |
| req_src_addr | input | REQ_AW | Bitmap source address (wrapped) |
| req_ready | output | 1 | Engine idle, request may be accepted |
| done | output | 1 | One-cycle pulse after the write cycle |
| mem_addr | output | AW | Destination address for read and write |
| mem_rd_en | output | 1 | Destination read strobe |
| mem_rdata | input | PIX_W | Destination read data, one cycle after strobe |
| mem_wr_en | output | 1 | Destination write strobe |
| mem_wdata | output | PIX_W | Write data |
| bmp_addr | output | AW | Source address on the second read port |
| bmp_rdata | input | PIX_W | Source read data, one cycle after `mem_rd_en` |

## Verification
A behavioural model steps through each request alongside the engine and compares strobes, addresses, write data and `done` on every clock.

The bench targets these corner cases, each with the failure it would expose:
- All sixteen operation codes are run against known destination bytes, so a swapped or mis-inverted code writes a wrong byte.
- Code 3 must leave memory untouched; a design that wrote anyway would show a stray write strobe.
- Requests held high while the engine is busy must not slip in; a design that accepted them would corrupt an address the bench later checks for its preload value.
- Addresses beyond the memory depth must wrap, and selector 3 must fall back to the background colour when the bitmap path is disabled; mistakes in either show up as wrong addresses or wrong pixel values.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MIX,
        ST_WRITE
    } rop_state_e;

    typedef enum logic [2:0] {
        CSEL_FG_MIX = 3'd0,
        CSEL_BG_MIX = 3'd1,
        CSEL_FG_COL = 3'd2,
        CSEL_BG_COL = 3'd3,
        CSEL_XFER   = 3'd4
    } cfg_sel_e;

    localparam int NUM_CFG_REGS = 5;

    // field layout inside a mix register
    localparam int MIX_CODE_LSB = 0;
    localparam int MIX_CODE_W   = 4;
    localparam int MIX_SRC_LSB  = 5;
    localparam int MIX_SRC_W    = 2;

    localparam logic [MIX_CODE_W-1:0] MIX_KEEP = 4'h3;

    localparam logic [MIX_SRC_W-1:0] SRC_BG   = 2'd0;
    localparam logic [MIX_SRC_W-1:0] SRC_FG   = 2'd1;
    localparam logic [MIX_SRC_W-1:0] SRC_XFER = 2'd2;
    localparam logic [MIX_SRC_W-1:0] SRC_BMP  = 2'd3;

endpackage

// File: rtl/rop_cfg_regs.sv
module rop_cfg_regs
    import rop_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] fg_mix,
    output logic [REG_W-1:0] bg_mix,
    output logic [REG_W-1:0] fg_col,
    output logic [REG_W-1:0] bg_col,
    output logic [REG_W-1:0] xfer
);

    logic [REG_W-1:0] regs_q [NUM_CFG_REGS];

    for (genvar gi = 0; gi < NUM_CFG_REGS; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (we && (sel == 3'(gi))) begin
                regs_q[gi] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(sel) < NUM_CFG_REGS) begin
            rdata = regs_q[sel];
        end
    end

    assign fg_mix = regs_q[CSEL_FG_MIX];
    assign bg_mix = regs_q[CSEL_BG_MIX];
    assign fg_col = regs_q[CSEL_FG_COL];
    assign bg_col = regs_q[CSEL_BG_COL];
    assign xfer   = regs_q[CSEL_XFER];

endmodule

// File: rtl/rop_src_mux.sv
module rop_src_mux
    import rop_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [MIX_SRC_W-1:0] sel,
    input  logic                 bmp_en,
    input  logic [PIX_W-1:0]     bg_pix,
    input  logic [PIX_W-1:0]     fg_pix,
    input  logic [PIX_W-1:0]     xfer_pix,
    input  logic [PIX_W-1:0]     bmp_pix,
    output logic [PIX_W-1:0]     src
);

    always_comb begin
        unique case (sel)
            SRC_BG:   src = bg_pix;
            SRC_FG:   src = fg_pix;
            SRC_XFER: src = xfer_pix;
            SRC_BMP:  src = bmp_en ? bmp_pix : bg_pix;
            default:  src = bg_pix;
        endcase
    end

endmodule

// File: rtl/rop_mix_alu.sv
module rop_mix_alu
    import rop_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [MIX_CODE_W-1:0] code,
    input  logic [PIX_W-1:0]      s,
    input  logic [PIX_W-1:0]      d,
    output logic [PIX_W-1:0]      res
);

    always_comb begin
        unique case (code)
            4'h0: res = ~d;
            4'h1: res = '0;
            4'h2: res = '1;
            4'h3: res = d;
            4'h4: res = ~s;
            4'h5: res = s ^ d;
            4'h6: res = ~(s ^ d);
            4'h7: res = s;
            4'h8: res = ~(s & d);
            4'h9: res = ~s | d;
            4'hA: res = s | ~d;
            4'hB: res = s | d;
            4'hC: res = s & d;
            4'hD: res = s & ~d;
            4'hE: res = ~s & d;
            4'hF: res = ~(s | d);
            default: res = d;
        endcase
    end

endmodule

// File: rtl/rop_pixel_rmw.sv
module rop_pixel_rmw
    import rop_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int REG_W     = 16,
    parameter int MEM_DEPTH = 1000,
    parameter int REQ_AW    = 16,
    localparam int AW       = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bitmap_en,
    input  logic              req_valid,
    input  logic              req_fg,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [REQ_AW-1:0] req_src_addr,
    output logic              req_ready,
    output logic              done,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_en,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              mem_wr_en,
    output logic [PIX_W-1:0]  mem_wdata,
    output logic [AW-1:0]     bmp_addr,
    input  logic [PIX_W-1:0]  bmp_rdata
);

    rop_state_e       state_q, state_d;
    logic [AW-1:0]    addr_q, src_addr_q;
    logic [REG_W-1:0] mix_q;
    logic [PIX_W-1:0] result_q;
    logic             done_q;

    logic [REG_W-1:0] fg_mix, bg_mix, fg_col, bg_col, xfer;
    logic [PIX_W-1:0] src_pix, mix_res;
    logic             accept;

    function automatic logic [AW-1:0] wrap_addr(input logic [REQ_AW-1:0] a);
        return AW'(a % REQ_AW'(MEM_DEPTH));
    endfunction

    rop_cfg_regs #(.REG_W(REG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fg_mix (fg_mix),
        .bg_mix (bg_mix),
        .fg_col (fg_col),
        .bg_col (bg_col),
        .xfer   (xfer)
    );

    rop_src_mux #(.PIX_W(PIX_W)) u_src (
        .sel      (mix_q[MIX_SRC_LSB +: MIX_SRC_W]),
        .bmp_en   (bitmap_en),
        .bg_pix   (bg_col[PIX_W-1:0]),
        .fg_pix   (fg_col[PIX_W-1:0]),
        .xfer_pix (xfer[PIX_W-1:0]),
        .bmp_pix  (bmp_rdata),
        .src      (src_pix)
    );

    rop_mix_alu #(.PIX_W(PIX_W)) u_alu (
        .code (mix_q[MIX_CODE_LSB +: MIX_CODE_W]),
        .s    (src_pix),
        .d    (mem_rdata),
        .res  (mix_res)
    );

    // upper colour bytes and spare mix bits are not used for byte pixels
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{fg_col[REG_W-1:PIX_W], bg_col[REG_W-1:PIX_W],
                               xfer[REG_W-1:PIX_W], mix_q[REG_W-1:MIX_SRC_LSB+MIX_SRC_W],
                               mix_q[MIX_SRC_LSB-1:MIX_CODE_W]};

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  state_d = ST_MIX;
            ST_MIX:   state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            src_addr_q <= '0;
            mix_q      <= '0;
            result_q   <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (state_q == ST_WRITE);
            if (accept) begin
                addr_q     <= wrap_addr(req_addr);
                src_addr_q <= wrap_addr(req_src_addr);
                mix_q      <= req_fg ? fg_mix : bg_mix;
            end
            if (state_q == ST_MIX) begin
                result_q <= mix_res;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_rd_en = (state_q == ST_READ);
        mem_wr_en = (state_q == ST_WRITE) &&
                    (mix_q[MIX_CODE_LSB +: MIX_CODE_W] != MIX_KEEP);
        mem_addr  = addr_q;
        bmp_addr  = src_addr_q;
        mem_wdata = result_q;
        done      = done_q;
    end

endmodule

// File: rtl/rop_pixel_rmw_chk.sv
module rop_pixel_rmw_chk #(
    parameter int AW        = 10,
    parameter int MEM_DEPTH = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic          done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_rd_en && !mem_wr_en && !done));

    // R3
    accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, done}));

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd_en, 3));

    // R4
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !mem_rd_en);

    // R10
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> ({1'b0, mem_addr} < (AW+1)'(MEM_DEPTH)));

endmodule

bind rop_pixel_rmw rop_pixel_rmw_chk #(.AW(AW), .MEM_DEPTH(MEM_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .done      (done)
);

// File: tb/rop_pixel_rmw_test.sv
module rop_pixel_rmw_test;

    localparam int D  = 1000;
    localparam int AW = $clog2(D);

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_sel = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] cfg_rdata;
    logic        bitmap_en = 0;
    logic        req_valid = 0;
    logic        req_fg = 0;
    logic [15:0] req_addr = 0;
    logic [15:0] req_src_addr = 0;
    logic        req_ready, done, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr, bmp_addr;
    logic [7:0]  mem_rdata = 0, bmp_rdata = 0, mem_wdata;

    rop_pixel_rmw uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bitmap_en(bitmap_en),
        .req_valid(req_valid), .req_fg(req_fg), .req_addr(req_addr),
        .req_src_addr(req_src_addr), .req_ready(req_ready), .done(done),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .bmp_addr(bmp_addr),
        .bmp_rdata(bmp_rdata)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // memory seen by the design, and the model's own copy
    logic [7:0] fb [D];
    logic [7:0] ref_fb [D];

    always @(posedge clk) begin
        if (mem_wr_en) fb[mem_addr] <= mem_wdata;
        if (mem_rd_en) begin
            mem_rdata <= fb[mem_addr];
            bmp_rdata <= fb[bmp_addr];
        end
    end

    // reference model
    logic [15:0] r_fgm = 0, r_bgm = 0, r_fgc = 0, r_bgc = 0, r_xf = 0;
    int ph = 0, exp_addr = 0, exp_baddr = 0;
    logic [15:0] exp_mix = 0;
    logic [7:0]  exp_res = 0;
    bit exp_done = 0;

    function automatic logic [7:0] ref_rop(input int code, input logic [7:0] s, input logic [7:0] d);
        logic [7:0] r;
        case (code)
            0: r = ~d;           1: r = 8'h00;        2: r = 8'hFF;       3: r = d;
            4: r = ~s;           5: r = s ^ d;        6: r = ~(s ^ d);    7: r = s;
            8: r = ~(s & d);     9: r = (~s) | d;     10: r = s | (~d);   11: r = s | d;
            12: r = s & d;       13: r = s & (~d);    14: r = (~s) & d;   default: r = ~(s | d);
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        logic [7:0] s;
        if (!rst_n) begin
            ph = 0; exp_done = 0;
            r_fgm = 0; r_bgm = 0; r_fgc = 0; r_bgc = 0; r_xf = 0;
        end else begin
            exp_done = 0;
            case (ph)
                0: if (req_valid) begin
                    exp_addr  = int'(req_addr) % D;
                    exp_baddr = int'(req_src_addr) % D;
                    exp_mix   = req_fg ? r_fgm : r_bgm;
                    ph = 1;
                end
                1: ph = 2;
                2: begin
                    case (exp_mix[6:5])
                        2'd0: s = r_bgc[7:0];
                        2'd1: s = r_fgc[7:0];
                        2'd2: s = r_xf[7:0];
                        default: s = bitmap_en ? ref_fb[exp_baddr] : r_bgc[7:0];
                    endcase
                    exp_res = ref_rop(int'(exp_mix[3:0]), s, ref_fb[exp_addr]);
                    ph = 3;
                end
                default: begin
                    if (exp_mix[3:0] != 4'h3) ref_fb[exp_addr] = exp_res;
                    exp_done = 1;
                    ph = 0;
                end
            endcase
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: r_fgm = cfg_wdata;
                    3'd1: r_bgm = cfg_wdata;
                    3'd2: r_fgc = cfg_wdata;
                    3'd3: r_bgc = cfg_wdata;
                    3'd4: r_xf  = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            check(req_ready === (ph == 0), "R3 ready", int'(req_ready), int'(ph == 0));
            check(mem_rd_en === (ph == 1), "R3 read strobe", int'(mem_rd_en), int'(ph == 1));
            if (ph == 1) begin
                check(int'(mem_addr) == exp_addr, "R10 dest addr", int'(mem_addr), exp_addr);
                check(int'(bmp_addr) == exp_baddr, "R10 source addr", int'(bmp_addr), exp_baddr);
            end
            check(mem_wr_en === (ph == 3 && exp_mix[3:0] != 4'h3), "R7 write strobe",
                  int'(mem_wr_en), int'(ph == 3 && exp_mix[3:0] != 4'h3));
            if (ph == 3 && exp_mix[3:0] != 4'h3) begin
                check(mem_wdata == exp_res, "R5/R6/R8 result", int'(mem_wdata), int'(exp_res));
                check(int'(mem_addr) == exp_addr, "R10 write addr", int'(mem_addr), exp_addr);
            end
            check(done === exp_done, "R3 done", int'(done), int'(exp_done));
        end
    end

    task automatic cfg_write(input int sel, input logic [15:0] v);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = v;
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic cfg_check(input int sel, input logic [15:0] v, input string tag);
        cfg_sel = 3'(sel);
        #1;
        check(cfg_rdata == v, tag, int'(cfg_rdata), int'(v));
    endtask

    task automatic run_op(input bit fg, input int a, input int sa, input string tag);
        req_valid = 1; req_fg = fg; req_addr = 16'(a); req_src_addr = 16'(sa);
        @(posedge clk); #2;
        req_valid = 0;
        repeat (3) @(posedge clk);
        #2;
        check(fb[a % D] == ref_fb[a % D], tag, int'(fb[a % D]), int'(ref_fb[a % D]));
    endtask

    task automatic finish_sim;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        check(0, "watchdog", 0, 1);
        finish_sim;
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            fb[i] = pat(i);
            ref_fb[i] = pat(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1 ready in reset", int'(req_ready), 1);
        check(done === 1'b0, "R1 done in reset", int'(done), 0);
        check(mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R1 strobes in reset",
              int'({mem_rd_en, mem_wr_en}), 0);
        for (int k = 0; k < 5; k++) cfg_check(k, 16'h0000, "R1 config cleared");
        @(posedge clk); #2;
        rst_n = 1;
        chk_on = 1;

        // R2 register write and readback
        cfg_write(0, 16'hBEEF);
        cfg_write(1, 16'h1234);
        cfg_write(2, 16'hA55A);
        cfg_write(3, 16'h3CC3);
        cfg_write(4, 16'h0F96);
        cfg_check(0, 16'hBEEF, "R2 fg mix");
        cfg_check(1, 16'h1234, "R2 bg mix");
        cfg_check(2, 16'hA55A, "R2 fg colour");
        cfg_check(3, 16'h3CC3, "R2 bg colour");
        cfg_check(4, 16'h0F96, "R2 transfer");
        for (int k = 5; k < 8; k++) cfg_check(k, 16'h0000, "R2 unused select");

        // R5 / R6 every operation code, source = fg colour
        for (int c = 0; c < 16; c++) begin
            cfg_write(0, 16'hF020 | 16'(c));
            run_op(1, 100 + c * 3, 0, c < 8 ? "R5 operation" : "R6 operation");
            if (c == 3) check(fb[109] == pat(109), "R7 keep pixel", int'(fb[109]), int'(pat(109)));
        end

        // R8 / R11 sources and mix choice
        cfg_write(1, 16'h0007);
        run_op(0, 200, 0, "R8 bg source");
        check(fb[200] == 8'hC3, "R8 bg colour byte", int'(fb[200]), 'hC3);
        cfg_write(1, 16'h0047);
        run_op(0, 201, 0, "R8 transfer source");
        check(fb[201] == 8'h96, "R8 transfer byte", int'(fb[201]), 'h96);
        cfg_write(0, 16'h0027);
        cfg_write(1, 16'h0007);
        run_op(0, 204, 0, "R11 bg mix");
        check(fb[204] == 8'hC3, "R11 bg mix value", int'(fb[204]), 'hC3);
        run_op(1, 205, 0, "R11 fg mix");
        check(fb[205] == 8'h5A, "R11 fg mix value", int'(fb[205]), 'h5A);

        // R9 bitmap source
        cfg_write(0, 16'h0067);
        bitmap_en = 1;
        run_op(1, 202, 500, "R9 bitmap enabled");
        check(fb[202] == pat(500), "R9 bitmap byte", int'(fb[202]), int'(pat(500)));
        bitmap_en = 0;
        run_op(1, 203, 501, "R9 bitmap disabled");
        check(fb[203] == 8'hC3, "R9 fallback byte", int'(fb[203]), 'hC3);

        // R10 wrap
        cfg_write(0, 16'h0027);
        run_op(1, 1007, 0, "R10 dest wrap");
        check(fb[7] == 8'h5A, "R10 wrapped pixel", int'(fb[7]), 'h5A);
        cfg_write(0, 16'h0067);
        bitmap_en = 1;
        run_op(1, 2010, 1600, "R10 source wrap");
        check(fb[10] == pat(600), "R10 wrapped source", int'(fb[10]), int'(pat(600)));
        bitmap_en = 0;

        // R4 request changed while busy
        cfg_write(1, 16'h0000);
        req_valid = 1; req_fg = 0; req_addr = 16'd300;
        @(posedge clk); #2;
        req_addr = 16'd301;
        @(posedge clk); #2;
        @(posedge clk); #2;
        req_valid = 0;
        @(posedge clk); #2;
        check(fb[300] == ~pat(300), "R4 accepted pixel", int'(fb[300]), int'(~pat(300)));
        check(fb[301] == pat(301), "R4 busy request ignored", int'(fb[301]), int'(pat(301)));

        // back-to-back requests held high
        cfg_write(0, 16'h0025);
        req_valid = 1; req_fg = 1; req_addr = 16'd400;
        repeat (6) @(posedge clk);
        #2;
        req_valid = 0;
        repeat (5) @(posedge clk);
        #2;

        begin
            int mism = 0;
            for (int i = 0; i < D; i++) if (fb[i] !== ref_fb[i]) mism++;
            check(mism == 0, "R4/R10 memory image", mism, 0);
        end
        chk_on = 0;
        finish_sim;
    end

endmodule